// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Front End

This block is the bus-facing half of a single-wire slave device. It runs on the system clock and counts time with a one-microsecond tick input. It watches a synchronised copy of the shared line and drives an open-drain pull-down enable. It tells apart a long low pulse, which is a bus reset, from a short one, which is a bit slot. It answers every reset with a presence pulse. It turns write slots into received bits and drives read slots with its own bits.

Above the slot layer, the block holds a fixed 64-bit identity and carries out the four identity-level commands: read, match, search and skip. Read, match and skip each select the device when they complete. From then until the next bus reset, every group of eight slots passes through a byte channel to the memory-command layer above. That layer receives bytes from the master and can queue one byte at a time to send back. Search only arbitrates: it never selects the device.

Top module: `ow_rom_slave`

## Requirements
- R1: A low period of at least RESET_MIN ticks, ended by a rising edge, is a bus reset. After that edge the block waits PRES_WAIT ticks and then pulls the line for PRES_LEN ticks. A low period shorter than RESET_MIN produces no presence pulse.
- R2: Each falling edge outside a presence pulse opens a slot. The line is sampled SAMPLE_AT ticks after the edge: low decodes as 0 and high as 1. Bytes are assembled least significant bit first.
- R3: In a slot where the block sends a 0, it pulls the line from the tick after the falling edge for READ_HOLD ticks. When it sends a 1, it does not pull the line.
- R4: The identity is built from three fields, lowest bits first:
  - bits 7:0 hold the family code 0Bh;
  - bits 55:8 hold the SERIAL parameter;
  - bits 63:56 hold a CRC-8 over bits 55:0, taken least significant bit first, with polynomial x^8+x^5+x^4+1 (reflected constant 8Ch) and a zero start value.
  The command 33h sends all 64 identity bits, least significant first, and then selects the device.
- R5: The command 55h compares the next 64 received bits with the identity. If all of them match, the device is selected. On the first mismatch the block stays silent until a reset: it pulls no read slot and stays deselected.
- R6: The command CCh selects the device immediately.
- R7: The command F0h handles the identity one bit at a time, in three slots per bit: the block sends the bit, then sends its complement, then reads the master's choice. If the choice differs from its own bit, the block drops out and stays silent until a reset. After bit 63 it goes silent and stays deselected.
- R8: While selected, every eight slots produce a one-cycle rx_valid with the received byte on rx_data.
- R9: While selected, a byte offered on tx_data with tx_valid is taken only at a byte boundary and only between slots, and tx_taken pulses for one cycle when it is taken. The byte is then sent in the next eight slots, least significant bit first. rx_valid pulses only while the device is selected.
- R10: Any bus reset deselects the device, throws away any partial byte, and returns the block to waiting for an identity command. A command byte other than the four listed leaves the block silent until the next reset.
- R11: Until the first bus reset after rst_n is released, the block ignores all slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| bus_in | input | 1 | Synchronised level of the shared line |
| bus_pull | output | 1 | Pull-down enable for the open-drain driver |
| bus_reset | output | 1 | One-cycle pulse when a bus reset ends |
| selected | output | 1 | The memory-command layer owns the byte channel |
| rx_data | output | 8 | Last byte received while selected |
| rx_valid | output | 1 | One-cycle strobe marking a new rx_data |
| tx_data | input | 8 | Byte to send in the next eight slots |
| tx_valid | input | 1 | tx_data is ready to be taken |
| tx_taken | output | 1 | One-cycle pulse when tx_data is latched |

## Verification
The assertions check four things on every cycle:
- The line is never pulled in the cycle after a bus reset.
- Selection is dropped after every bus reset.
- A single pull never lasts longer than the presence pulse.
- Byte strobes and transmit hand-offs happen only while the device is selected, and receive strobes never occur back to back.

Only the bench scenarios can show the protocol content: that the identity comes out in the right bit order with a valid CRC, that match and search drop out at the right bit and stay silent, and that a reset in the middle of a byte throws away the partial byte.

// File: rtl/ow_pkg.sv
package ow_pkg;

    // Slot-level timer states
    typedef enum logic [1:0] {
        T_IDLE,
        T_SLOT,
        T_PWAIT,
        T_PRES
    } tstate_e;

    // Identity-command states
    typedef enum logic [2:0] {
        R_WAIT,
        R_CMD,
        R_READ,
        R_MATCH,
        R_SEARCH,
        R_SEL,
        R_MUTE
    } rstate_e;

    localparam logic [7:0] CMD_READ   = 8'h33;
    localparam logic [7:0] CMD_MATCH  = 8'h55;
    localparam logic [7:0] CMD_SKIP   = 8'hCC;
    localparam logic [7:0] CMD_SEARCH = 8'hF0;

    // Reflected CRC-8 (x^8+x^5+x^4+1), zero start, fed bit 0 first
    function automatic logic [7:0] crc8_lsb(input logic [55:0] d);
        logic [7:0] c;
        c = '0;
        for (int i = 0; i < 56; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ 8'h8C;
            else             c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/ow_slot_timer.sv
module ow_slot_timer #(
    parameter int RESET_MIN = 480,
    parameter int PRES_WAIT = 30,
    parameter int PRES_LEN  = 120,
    parameter int SAMPLE_AT = 30,
    parameter int READ_HOLD = 45
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic bus_in,
    input  logic tx_bit,
    output logic bit_valid,
    output logic bit_val,
    output logic bus_reset,
    output logic slot_busy,
    output logic bus_pull
);
    import ow_pkg::*;

    localparam int CW = $clog2(RESET_MIN + 2) + 1;

    typedef struct packed {
        tstate_e        st;
        logic [CW-1:0]  cnt;
        logic [CW-1:0]  low;
        logic           line;
        logic           pull;
    } tim_t;

    tim_t t_q, t_d;
    logic fall, rise;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        t_d       = t_q;
        bit_valid = 1'b0;
        bit_val   = bus_in;
        bus_reset = 1'b0;
        fall      = t_q.line & ~bus_in;
        rise      = ~t_q.line & bus_in;
        cnt_inc   = (tick && t_q.cnt != '1) ? t_q.cnt + 1'b1 : t_q.cnt;
        t_d.line  = bus_in;

        if (bus_in) begin
            t_d.low = '0;
        end else if (tick && t_q.low < CW'(RESET_MIN)) begin
            t_d.low = t_q.low + 1'b1;
        end

        if (rise && t_q.low >= CW'(RESET_MIN) && t_q.st != T_PRES) begin
            bus_reset = 1'b1;
            t_d.st    = T_PWAIT;
            t_d.cnt   = '0;
            t_d.pull  = 1'b0;
        end else begin
            case (t_q.st)
                T_IDLE: begin
                    if (fall) begin
                        t_d.st   = T_SLOT;
                        t_d.cnt  = '0;
                        t_d.pull = ~tx_bit;
                    end
                end
                T_SLOT: begin
                    t_d.cnt = cnt_inc;
                    if (tick && t_q.cnt == CW'(SAMPLE_AT - 1)) bit_valid = 1'b1;
                    if (tick && t_q.cnt == CW'(READ_HOLD - 1)) t_d.pull = 1'b0;
                    if (t_q.cnt >= CW'(SAMPLE_AT) && bus_in)  t_d.st = T_IDLE;
                end
                T_PWAIT: begin
                    t_d.cnt = cnt_inc;
                    if (tick && t_q.cnt == CW'(PRES_WAIT - 1)) begin
                        t_d.st   = T_PRES;
                        t_d.cnt  = '0;
                        t_d.pull = 1'b1;
                    end
                end
                T_PRES: begin
                    t_d.cnt = cnt_inc;
                    if (tick && t_q.cnt == CW'(PRES_LEN - 1)) begin
                        t_d.st   = T_IDLE;
                        t_d.pull = 1'b0;
                    end
                end
                default: t_d.st = T_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q      <= '0;
            t_q.st   <= T_IDLE;
            t_q.line <= 1'b1;
        end else begin
            t_q <= t_d;
        end
    end

    assign slot_busy = (t_q.st != T_IDLE);
    assign bus_pull  = t_q.pull;

endmodule

// File: rtl/ow_rom_fsm.sv
module ow_rom_fsm #(
    parameter logic [63:0] ROM_ID = 64'h0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_valid,
    input  logic       bit_val,
    input  logic       bus_reset,
    input  logic       slot_busy,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_bit,
    output logic       selected,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       tx_taken
);
    import ow_pkg::*;

    localparam int ID_BITS = 64;
    localparam int IW      = $clog2(ID_BITS);

    typedef struct packed {
        rstate_e        st;
        logic [IW-1:0]  idx;
        logic [1:0]     ph;
        logic [7:0]     sh;
        logic [2:0]     bcnt;
        logic [7:0]     txsh;
        logic           txbusy;
        logic [7:0]     rxd;
        logic           rxv;
        logic           taken;
    } rom_t;

    rom_t r_q, r_d;
    logic idbit;
    logic [7:0] nsh;

    always_comb begin
        r_d       = r_q;
        r_d.rxv   = 1'b0;
        r_d.taken = 1'b0;
        idbit     = ROM_ID[r_q.idx];
        nsh       = {bit_val, r_q.sh[7:1]};
        tx_bit    = 1'b1;

        case (r_q.st)
            R_READ:   tx_bit = idbit;
            R_SEARCH: tx_bit = (r_q.ph == 2'd0) ? idbit :
                               (r_q.ph == 2'd1) ? ~idbit : 1'b1;
            R_SEL:    tx_bit = r_q.txbusy ? r_q.txsh[0] : 1'b1;
            default:  tx_bit = 1'b1;
        endcase

        if (bus_reset) begin
            r_d.st     = R_CMD;
            r_d.idx    = '0;
            r_d.ph     = '0;
            r_d.bcnt   = '0;
            r_d.sh     = '0;
            r_d.txbusy = 1'b0;
        end else begin
            case (r_q.st)
                R_CMD: begin
                    if (bit_valid) begin
                        r_d.sh   = nsh;
                        r_d.bcnt = r_q.bcnt + 1'b1;
                        if (r_q.bcnt == 3'd7) begin
                            r_d.idx = '0;
                            r_d.ph  = '0;
                            case (nsh)
                                CMD_READ:   r_d.st = R_READ;
                                CMD_MATCH:  r_d.st = R_MATCH;
                                CMD_SKIP:   r_d.st = R_SEL;
                                CMD_SEARCH: r_d.st = R_SEARCH;
                                default:    r_d.st = R_MUTE;
                            endcase
                        end
                    end
                end
                R_READ: begin
                    if (bit_valid) begin
                        r_d.idx = r_q.idx + 1'b1;
                        if (r_q.idx == IW'(ID_BITS - 1)) r_d.st = R_SEL;
                    end
                end
                R_MATCH: begin
                    if (bit_valid) begin
                        if (bit_val != idbit)                 r_d.st = R_MUTE;
                        else if (r_q.idx == IW'(ID_BITS - 1)) r_d.st = R_SEL;
                        else                                  r_d.idx = r_q.idx + 1'b1;
                    end
                end
                R_SEARCH: begin
                    if (bit_valid) begin
                        if (r_q.ph != 2'd2) begin
                            r_d.ph = r_q.ph + 1'b1;
                        end else if (bit_val != idbit || r_q.idx == IW'(ID_BITS - 1)) begin
                            r_d.st = R_MUTE;
                        end else begin
                            r_d.idx = r_q.idx + 1'b1;
                            r_d.ph  = '0;
                        end
                    end
                end
                R_SEL: begin
                    if (bit_valid) begin
                        r_d.sh   = nsh;
                        r_d.txsh = r_q.txsh >> 1;
                        r_d.bcnt = r_q.bcnt + 1'b1;
                        if (r_q.bcnt == 3'd7) begin
                            r_d.rxd    = nsh;
                            r_d.rxv    = 1'b1;
                            r_d.txbusy = 1'b0;
                        end
                    end else if (!r_q.txbusy && r_q.bcnt == 3'd0 && tx_valid && !slot_busy) begin
                        r_d.txsh   = tx_data;
                        r_d.txbusy = 1'b1;
                        r_d.taken  = 1'b1;
                    end
                end
                default: r_d.st = r_q.st;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= R_WAIT;
        end else begin
            r_q <= r_d;
        end
    end

    assign selected = (r_q.st == R_SEL);
    assign rx_data  = r_q.rxd;
    assign rx_valid = r_q.rxv;
    assign tx_taken = r_q.taken;

endmodule

// File: rtl/ow_rom_slave.sv
module ow_rom_slave #(
    parameter logic [7:0]  FAMILY    = 8'h0B,
    parameter logic [47:0] SERIAL    = 48'h3C5A_9617_E2D4,
    parameter int          RESET_MIN = 480,
    parameter int          PRES_WAIT = 30,
    parameter int          PRES_LEN  = 120,
    parameter int          SAMPLE_AT = 30,
    parameter int          READ_HOLD = 45
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_us,
    input  logic       bus_in,
    output logic       bus_pull,
    output logic       bus_reset,
    output logic       selected,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_taken
);
    localparam logic [63:0] ROM_ID = {ow_pkg::crc8_lsb({SERIAL, FAMILY}), SERIAL, FAMILY};

    logic bit_valid, bit_val, slot_busy, tx_bit;

    ow_slot_timer #(
        .RESET_MIN (RESET_MIN),
        .PRES_WAIT (PRES_WAIT),
        .PRES_LEN  (PRES_LEN),
        .SAMPLE_AT (SAMPLE_AT),
        .READ_HOLD (READ_HOLD)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_us),
        .bus_in    (bus_in),
        .tx_bit    (tx_bit),
        .bit_valid (bit_valid),
        .bit_val   (bit_val),
        .bus_reset (bus_reset),
        .slot_busy (slot_busy),
        .bus_pull  (bus_pull)
    );

    ow_rom_fsm #(
        .ROM_ID (ROM_ID)
    ) rom_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (bit_valid),
        .bit_val   (bit_val),
        .bus_reset (bus_reset),
        .slot_busy (slot_busy),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_bit    (tx_bit),
        .selected  (selected),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .tx_taken  (tx_taken)
    );

endmodule

// File: rtl/ow_rom_slave_chk.sv
module ow_rom_slave_chk #(
    parameter int PRES_LEN = 120
) (
    input logic clk,
    input logic rst_n,
    input logic tick_us,
    input logic bus_pull,
    input logic bus_reset,
    input logic selected,
    input logic rx_valid,
    input logic tx_taken
);
    logic [15:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_q <= '0;
        else if (!bus_pull) run_q <= '0;
        else if (tick_us)   run_q <= run_q + 1'b1;
    end

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !bus_pull);

    assert_pull_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 16'(PRES_LEN));

    assert_deselect_on_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !selected);

    assert_rx_only_selected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> selected);

    assert_rx_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_take_only_selected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_taken |-> selected);

endmodule

bind ow_rom_slave ow_rom_slave_chk #(.PRES_LEN(PRES_LEN)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_us   (tick_us),
    .bus_pull  (bus_pull),
    .bus_reset (bus_reset),
    .selected  (selected),
    .rx_valid  (rx_valid),
    .tx_taken  (tx_taken)
);

// File: tb/ow_rom_slave_tb.sv
module ow_rom_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PRES_WAIT  = 30;
    localparam int PRES_LEN   = 120;
    localparam int READ_HOLD  = 45;
    localparam logic [7:0]  FAM = 8'h0B;
    localparam logic [47:0] SER = 48'h3C5A_9617_E2D4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_low = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic tx_valid = 1'b0;
    logic bus_in, bus_pull, bus_reset, selected, rx_valid, tx_taken;
    logic [7:0] rx_data;

    int checks = 0;
    int errors = 0;
    int pull_cycles = 0;
    int rx_cnt = 0;
    int take_cnt = 0;
    logic [7:0] last_rx = 8'h00;
    logic [63:0] exp_id;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    assign bus_in = !(master_low || bus_pull);

    ow_rom_slave dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_us  (1'b1),
        .bus_in   (bus_in),
        .bus_pull (bus_pull),
        .bus_reset(bus_reset),
        .selected (selected),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_taken (tx_taken)
    );

    always @(posedge clk) begin
        if (bus_pull) pull_cycles <= pull_cycles + 1;
        if (rx_valid) begin
            last_rx <= rx_data;
            rx_cnt  <= rx_cnt + 1;
        end
        if (tx_taken) take_cnt <= take_cnt + 1;
    end

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ow_reset(input int low_len, output int wait_c, output int pres_c);
        @(negedge clk);
        master_low = 1'b1;
        idle(low_len);
        master_low = 1'b0;
        wait_c = 0;
        while (!bus_pull && wait_c < 300) begin
            @(negedge clk);
            wait_c++;
        end
        pres_c = 0;
        while (bus_pull && pres_c < 500) begin
            @(negedge clk);
            pres_c++;
        end
        idle(20);
    endtask

    task automatic write_bit(input logic b);
        @(negedge clk);
        master_low = 1'b1;
        idle(b ? 5 : 70);
        master_low = 1'b0;
        idle(b ? 80 : 15);
    endtask

    task automatic read_bit(output logic b, output int pl);
        int p0;
        p0 = pull_cycles;
        @(negedge clk);
        master_low = 1'b1;
        idle(2);
        master_low = 1'b0;
        idle(10);
        b = bus_in;
        idle(68);
        pl = pull_cycles - p0;
        idle(5);
    endtask

    task automatic write_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) write_bit(v[i]);
    endtask

    task automatic read_byte(output logic [7:0] v);
        int pl;
        for (int i = 0; i < 8; i++) read_bit(v[i], pl);
    endtask

    function automatic logic [7:0] crc_of(input logic [63:0] d, input int n);
        logic [7:0] c;
        c = '0;
        for (int i = 0; i < n; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ 8'h8C;
            else             c = c >> 1;
        end
        return c;
    endfunction

    task automatic do_reset();
        int w, p;
        ow_reset(500, w, p);
    endtask

    initial begin
        int w, p, pl, bad, rx0, tk0, pc0;
        logic b, c;
        logic [7:0] v;
        logic [63:0] got, mid;
        logic [7:0] rx_pat[5];
        logic [7:0] tx_pat[4];
        int flips[3];

        rx_pat = '{8'h00, 8'hFF, 8'h5A, 8'h81, 8'hA5};
        tx_pat = '{8'h3C, 8'h00, 8'hFF, 8'h96};
        flips  = '{0, 31, 63};
        exp_id = {8'h00, SER, FAM};
        exp_id[63:56] = crc_of(exp_id, 56);

        idle(5);
        rst_n = 1'b1;
        idle(5);
        chk(!selected && !bus_pull, "R10 reset state", {62'd0, selected, bus_pull}, 64'd0);

        // R11: slots before the first bus reset are ignored
        pc0 = pull_cycles;
        write_byte(8'hCC);
        read_byte(v);
        chk(!selected && pull_cycles == pc0 && v == 8'hFF, "R11 ignored before reset",
            {55'd0, selected, v}, 64'h0FF);

        // R1: short low pulse is not a reset
        ow_reset(200, w, p);
        chk(w >= 300, "R1 short low no presence", 64'(w), 64'd300);

        // R1: proper reset and presence timing
        ow_reset(500, w, p);
        chk(w >= PRES_WAIT && w <= PRES_WAIT + 2, "R1 presence delay", 64'(w), 64'(PRES_WAIT + 1));
        chk(p >= PRES_LEN - 1 && p <= PRES_LEN + 1, "R1 presence length", 64'(p), 64'(PRES_LEN));

        // R4: read identity
        write_byte(8'h33);
        got = '0;
        bad = -1;
        for (int i = 0; i < 64; i++) begin
            read_bit(b, pl);
            got[i] = b;
            if (!b && bad < 0) bad = pl;
        end
        chk(got == exp_id, "R4 identity bits", got, exp_id);
        chk(got[7:0] == 8'h0B && crc_of(got, 64) == 8'h00, "R4 family and crc residue",
            {48'd0, got[7:0], crc_of(got, 64)}, 64'h0B00);
        chk(bad >= READ_HOLD - 1 && bad <= READ_HOLD + 1, "R3 read-0 pull length", 64'(bad), 64'(READ_HOLD));
        chk(selected, "R4 selected after read", {63'd0, selected}, 64'd1);

        // R2 R8: receive sweep
        foreach (rx_pat[k]) begin
            rx0 = rx_cnt;
            write_byte(rx_pat[k]);
            idle(2);
            chk(rx_cnt == rx0 + 1 && last_rx == rx_pat[k], "R2 R8 received byte",
                {24'd0, 32'(rx_cnt - rx0), last_rx}, {24'd0, 32'd1, rx_pat[k]});
        end

        // R9 R3: transmit sweep
        foreach (tx_pat[k]) begin
            tk0 = take_cnt;
            tx_data  = tx_pat[k];
            tx_valid = 1'b1;
            idle(3);
            tx_valid = 1'b0;
            read_byte(v);
            chk(v == tx_pat[k] && take_cnt == tk0 + 1, "R9 transmitted byte",
                {24'd0, 32'(take_cnt - tk0), v}, {24'd0, 32'd1, tx_pat[k]});
        end

        // R10: reset deselects
        ow_reset(500, w, p);
        chk(!selected && p >= PRES_LEN - 1, "R10 reset deselects", {63'd0, selected}, 64'd0);

        // R6: skip
        write_byte(8'hCC);
        chk(selected, "R6 skip selects", {63'd0, selected}, 64'd1);

        // R10: partial byte discarded by reset
        for (int i = 0; i < 4; i++) write_bit(1'b0);
        do_reset();
        write_byte(8'hCC);
        rx0 = rx_cnt;
        write_byte(8'h5A);
        idle(2);
        chk(rx_cnt == rx0 + 1 && last_rx == 8'h5A, "R10 partial byte dropped",
            {56'd0, last_rx}, 64'h5A);

        // R5: match correct
        do_reset();
        write_byte(8'h55);
        for (int i = 0; i < 64; i++) write_bit(exp_id[i]);
        chk(selected, "R5 match selects", {63'd0, selected}, 64'd1);

        // R5: match with one wrong bit
        foreach (flips[k]) begin
            do_reset();
            write_byte(8'h55);
            mid = exp_id;
            mid[flips[k]] = ~mid[flips[k]];
            for (int i = 0; i < 64; i++) write_bit(mid[i]);
            read_byte(v);
            chk(!selected && v == 8'hFF, "R5 mismatch silent", {55'd0, selected, v}, 64'h0FF);
        end

        // R7: full search
        do_reset();
        write_byte(8'hF0);
        bad = 0;
        for (int i = 0; i < 64; i++) begin
            read_bit(b, pl);
            read_bit(c, pl);
            if (b != exp_id[i] || c != !exp_id[i]) bad++;
            write_bit(exp_id[i]);
        end
        chk(bad == 0, "R7 search pairs", 64'(bad), 64'd0);
        read_byte(v);
        chk(!selected && v == 8'hFF, "R7 search ends silent", {55'd0, selected, v}, 64'h0FF);

        // R7: drop out at bit 10
        do_reset();
        write_byte(8'hF0);
        bad = 0;
        for (int i = 0; i < 14; i++) begin
            read_bit(b, pl);
            read_bit(c, pl);
            if (i <= 10 && (b != exp_id[i] || c != !exp_id[i])) bad++;
            if (i > 10 && (b != 1'b1 || c != 1'b1)) bad++;
            write_bit(i == 10 ? !exp_id[i] : exp_id[i]);
        end
        chk(bad == 0 && !selected, "R7 search drop-out", {31'd0, selected, 32'(bad)}, 64'd0);

        // R10: unknown command
        do_reset();
        write_byte(8'h12);
        read_byte(v);
        chk(!selected && v == 8'hFF, "R10 unknown command silent", {55'd0, selected, v}, 64'h0FF);

        summary();
    end

endmodule